// File: doc/BRIEF.md
# Position and Speed Snapshot Latch

This block freezes three pieces of motion data at one instant so that a control loop can later read a consistent set. The three values are the encoder position count, the most recent interval measured between velocity events, and the time that has passed since the last velocity event. The live values come from neighbouring logic. This block decides when to copy them and holds the copies.

A single mode bit in a small control register picks the trigger. With the bit set, a periodic loop-timer timeout strobe copies all three values, including the position count. With the bit clear, which is the reset default, each read of the live position count copies only the two timing values. In that mode software takes the position from the live counter itself, and the count snapshot keeps its old value.

Top module: `motion_snapshot`

## Requirements
- R1: With the mode bit set, a cycle with `tmo_strobe` high loads `snap_count`, `snap_interval` and `snap_elapsed` from `pos_count`, `ivl_value` and `evt_timer` of that same cycle. The new values appear on the outputs after that clock edge.
- R2: With the mode bit clear, a cycle with `count_read` high loads `snap_interval` and `snap_elapsed` from `ivl_value` and `evt_timer` of that cycle.
- R3: With the mode bit set, a `count_read` alone leaves `snap_interval` and `snap_elapsed` unchanged.
- R4: With the mode bit clear, a `tmo_strobe` alone leaves all three snapshot outputs unchanged.
- R5: In a cycle with neither strobe high, all three snapshot outputs keep their values.
- R6: After reset, all three snapshot outputs are zero and the mode bit is clear, so read-triggered latching is in effect.
- R7: When `tmo_strobe` and `count_read` are high in the same cycle, only the trigger chosen by the mode bit acts, and it captures that cycle's live values.
- R8: While the mode bit is clear, `snap_count` holds its value, even on a read.
- R9: The mode bit is bit 4 of `ctrl_wdata`, loaded when `ctrl_write` is high. The new mode governs from the next cycle on, so a strobe in the write cycle obeys the old mode.
- R10: The other bits of `ctrl_wdata` have no effect on latching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_write | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data; bit 4 selects the timeout trigger |
| tmo_strobe | input | 1 | One-cycle loop-timer timeout pulse |
| count_read | input | 1 | One-cycle pulse marking a read of the live position count |
| pos_count | input | 16 | Live encoder position count |
| ivl_value | input | 16 | Live interval between the last two velocity events |
| evt_timer | input | 16 | Live time since the last velocity event |
| snap_count | output | 16 | Latched position count |
| snap_interval | output | 16 | Latched interval |
| snap_elapsed | output | 16 | Latched elapsed time |

## Verification
The bench drives both strobes in the same cycle in each mode. A design that let both triggers act, or that gave priority to a fixed strobe, would capture in the wrong mode or move the count snapshot while reads are selected. It changes the mode in the same cycle as a strobe. A design that applied the new mode at once would latch on the write cycle, or fail to. It also writes control bytes with only the non-mode bits set, which catches a decoder that uses the wrong bit position, and it applies reset in the middle of a run while timeout mode is active. A design whose reset left timeout mode active would then latch on a timeout.

// File: rtl/msnap_pkg.sv
package msnap_pkg;
  parameter int unsigned DATA_W   = 16;
  parameter int unsigned CTRL_W   = 8;
  parameter int unsigned MODE_POS = 4;

  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic {
    SRC_READ    = 1'b0,
    SRC_TIMEOUT = 1'b1
  } latch_src_e;
endpackage

// File: rtl/msnap_rst_sync.sv
module msnap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/msnap_mode_reg.sv
module msnap_mode_reg
  import msnap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output latch_src_e        src
);
  latch_src_e src_q;
  latch_src_e src_d;

  always_comb begin
    src_d = src_q;
    if (wr_en) src_d = latch_src_e'(wdata[MODE_POS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_READ;
    else        src_q <= src_d;
  end

  assign src = src_q;
endmodule

// File: rtl/msnap_trig.sv
module msnap_trig
  import msnap_pkg::*;
(
  input  latch_src_e src,
  input  logic       tmo,
  input  logic       rd,
  output logic       ld_count,
  output logic       ld_timing
);
  always_comb begin
    ld_count  = 1'b0;
    ld_timing = 1'b0;
    unique case (src)
      SRC_TIMEOUT: begin
        ld_count  = tmo;
        ld_timing = tmo;
      end
      SRC_READ: begin
        ld_timing = rd;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msnap_hold_reg.sv
module msnap_hold_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (load) val_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign dout = val_q;
endmodule

// File: rtl/motion_snapshot.sv
module motion_snapshot
  import msnap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_write,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              tmo_strobe,
  input  logic              count_read,
  input  logic [DATA_W-1:0] pos_count,
  input  logic [DATA_W-1:0] ivl_value,
  input  logic [DATA_W-1:0] evt_timer,
  output logic [DATA_W-1:0] snap_count,
  output logic [DATA_W-1:0] snap_interval,
  output logic [DATA_W-1:0] snap_elapsed
);
  localparam int unsigned NSNAP = 3;

  logic       rst_q_n;
  latch_src_e mode_q;
  logic       ld_count;
  logic       ld_timing;

  logic [NSNAP-1:0]              snap_ld;
  logic [NSNAP-1:0][DATA_W-1:0]  snap_in;
  logic [NSNAP-1:0][DATA_W-1:0]  snap_out;

  msnap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  msnap_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr_en (ctrl_write),
    .wdata (ctrl_wdata),
    .src   (mode_q)
  );

  msnap_trig u_trig (
    .src       (mode_q),
    .tmo       (tmo_strobe),
    .rd        (count_read),
    .ld_count  (ld_count),
    .ld_timing (ld_timing)
  );

  assign snap_ld = {ld_timing, ld_timing, ld_count};
  assign snap_in = {evt_timer, ivl_value, pos_count};

  for (genvar g = 0; g < NSNAP; g++) begin : g_snap
    msnap_hold_reg #(.W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_q_n),
      .load  (snap_ld[g]),
      .din   (snap_in[g]),
      .dout  (snap_out[g])
    );
  end

  assign snap_count    = snap_out[0];
  assign snap_interval = snap_out[1];
  assign snap_elapsed  = snap_out[2];
endmodule

// File: rtl/msnap_chk.sv
module msnap_chk
  import msnap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input latch_src_e        mode,
  input logic              tmo,
  input logic              rd,
  input logic [DATA_W-1:0] cnt_in,
  input logic [DATA_W-1:0] ivl_in,
  input logic [DATA_W-1:0] tmr_in,
  input logic [DATA_W-1:0] s_cnt,
  input logic [DATA_W-1:0] s_ivl,
  input logic [DATA_W-1:0] s_elap
);
  p_tmo_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_TIMEOUT && tmo) |=>
      (s_cnt == $past(cnt_in) && s_ivl == $past(ivl_in) && s_elap == $past(tmr_in)));

  p_read_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_READ && rd) |=> (s_ivl == $past(ivl_in) && s_elap == $past(tmr_in)));

  p_read_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_TIMEOUT && rd && !tmo) |=> ($stable(s_ivl) && $stable(s_elap)));

  p_tmo_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_READ && tmo && !rd) |=> ($stable(s_cnt) && $stable(s_ivl) && $stable(s_elap)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo && !rd) |=> ($stable(s_cnt) && $stable(s_ivl) && $stable(s_elap)));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_READ) |=> $stable(s_cnt));
endmodule

bind motion_snapshot msnap_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .mode   (mode_q),
  .tmo    (tmo_strobe),
  .rd     (count_read),
  .cnt_in (pos_count),
  .ivl_in (ivl_value),
  .tmr_in (evt_timer),
  .s_cnt  (snap_count),
  .s_ivl  (snap_interval),
  .s_elap (snap_elapsed)
);

// File: tb/sim_motion_snapshot.sv
`timescale 1ns/1ps
module sim_motion_snapshot;
  typedef struct packed {
    logic        wr;
    logic [7:0]  wd;
    logic        tmo;
    logic        rd;
    logic [15:0] cnt;
    logic [15:0] ivl;
    logic [15:0] tmr;
    logic [15:0] e_cnt;
    logic [15:0] e_ivl;
    logic [15:0] e_elap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    // 0 R2 R8: read in default mode
    '{1'b0, 8'h00, 1'b0, 1'b1, 16'h1111, 16'h0A0A, 16'h0005, 16'h0000, 16'h0A0A, 16'h0005},
    // 1 R4: timeout ignored in read mode
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'h2222, 16'h0B0B, 16'h0006, 16'h0000, 16'h0A0A, 16'h0005},
    // 2 R5: idle hold
    '{1'b0, 8'h00, 1'b0, 1'b0, 16'h3333, 16'h0C0C, 16'h0007, 16'h0000, 16'h0A0A, 16'h0005},
    // 3 R9: write mode=1 with read, old mode governs
    '{1'b1, 8'h10, 1'b0, 1'b1, 16'h4444, 16'h0D0D, 16'h0008, 16'h0000, 16'h0D0D, 16'h0008},
    // 4 R3: read ignored in timeout mode
    '{1'b0, 8'h00, 1'b0, 1'b1, 16'h5555, 16'h0E0E, 16'h0009, 16'h0000, 16'h0D0D, 16'h0008},
    // 5 R1: timeout latches all three
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'h6666, 16'h0F0F, 16'h000A, 16'h6666, 16'h0F0F, 16'h000A},
    // 6 R7: both strobes in timeout mode
    '{1'b0, 8'h00, 1'b1, 1'b1, 16'h7777, 16'h1010, 16'h000B, 16'h7777, 16'h1010, 16'h000B},
    // 7 R9 R10: write 0xEF (mode clear) with timeout, old mode still set
    '{1'b1, 8'hEF, 1'b1, 1'b0, 16'h8888, 16'h1111, 16'h000C, 16'h8888, 16'h1111, 16'h000C},
    // 8 R7 R8 R10: both strobes in read mode, count held
    '{1'b0, 8'h00, 1'b1, 1'b1, 16'h9999, 16'h1212, 16'h000D, 16'h8888, 16'h1212, 16'h000D},
    // 9 R4: timeout ignored again
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hAAAA, 16'h1313, 16'h000E, 16'h8888, 16'h1212, 16'h000D}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_write;
  logic [7:0]  ctrl_wdata;
  logic        tmo_strobe;
  logic        count_read;
  logic [15:0] pos_count, ivl_value, evt_timer;
  logic [15:0] snap_count, snap_interval, snap_elapsed;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  motion_snapshot u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_write(ctrl_write), .ctrl_wdata(ctrl_wdata),
    .tmo_strobe(tmo_strobe), .count_read(count_read), .pos_count(pos_count),
    .ivl_value(ivl_value), .evt_timer(evt_timer), .snap_count(snap_count),
    .snap_interval(snap_interval), .snap_elapsed(snap_elapsed)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [7:0] wd, input logic t, input logic r,
                       input logic [15:0] c, input logic [15:0] i, input logic [15:0] m);
    ctrl_write = wr; ctrl_wdata = wd; tmo_strobe = t; count_read = r;
    pos_count = c; ivl_value = i; evt_timer = m;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    drive(0, 8'h00, 0, 0, 16'h0, 16'h0, 16'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 count reset", snap_count, 16'h0);
    chk("R6 interval reset", snap_interval, 16'h0);
    chk("R6 elapsed reset", snap_elapsed, 16'h0);

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].wr, TBL[k].wd, TBL[k].tmo, TBL[k].rd, TBL[k].cnt, TBL[k].ivl, TBL[k].tmr);
      @(negedge clk);
      drive(0, 8'h00, 0, 0, 16'h0, 16'h0, 16'h0);
      chk($sformatf("vec %0d count", k), snap_count, TBL[k].e_cnt);
      chk($sformatf("vec %0d interval", k), snap_interval, TBL[k].e_ivl);
      chk($sformatf("vec %0d elapsed", k), snap_elapsed, TBL[k].e_elap);
    end

    // R10: bit-4-only write selects timeout mode; non-mode bits alone do not
    drive(1, 8'hEF, 0, 0, 16'h0, 16'h0, 16'h0); @(negedge clk);
    drive(0, 8'h00, 1, 0, 16'h1234, 16'h5678, 16'h0042); @(negedge clk);
    drive(0, 8'h00, 0, 0, 16'h0, 16'h0, 16'h0);
    chk("R10 non-mode bits give no timeout latch", snap_count, 16'h8888);

    // Mid-run reset while timeout mode is active
    drive(1, 8'h10, 0, 0, 16'h0, 16'h0, 16'h0); @(negedge clk);
    drive(0, 8'h00, 1, 0, 16'hBEEF, 16'h0101, 16'h0202); @(negedge clk);
    drive(0, 8'h00, 0, 0, 16'h0, 16'h0, 16'h0);
    chk("R1 timeout latch before reset", snap_count, 16'hBEEF);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 count cleared by reset", snap_count, 16'h0);
    chk("R6 interval cleared by reset", snap_interval, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(0, 8'h00, 1, 0, 16'hC0DE, 16'h0303, 16'h0404); @(negedge clk);
    drive(0, 8'h00, 0, 0, 16'h0, 16'h0, 16'h0);
    chk("R6 default mode ignores timeout", snap_count, 16'h0);
    chk("R6 default mode ignores timeout interval", snap_interval, 16'h0);
    drive(0, 8'h00, 0, 1, 16'hC0DE, 16'h0505, 16'h0606); @(negedge clk);
    drive(0, 8'h00, 0, 0, 16'h0, 16'h0, 16'h0);
    chk("R6 default mode read latches interval", snap_interval, 16'h0505);
    chk("R6 default mode read latches elapsed", snap_elapsed, 16'h0606);
    chk("R8 count held on read", snap_count, 16'h0);

    finish_run();
  end
endmodule